// File: doc/BRIEF.md
# Serial Port Command Control Unit

This block is the write-only command register of a serial port. Software writes single-cycle write-one strobes through a simple register bus. The block turns those strobes into persistent control flags: receiver on, transmitter on, master mode, receive blocking and transmitter high-impedance. It also issues one-cycle flush pulses that empty the receive or transmit buffer together with its shift register.

The receive datapath reports two things: that a frame is partway through reception, and that a frame has just completed. In return it receives an abort pulse and a load qualifier. The abort pulse drops a partial frame when the receiver is switched off mid-frame. The load qualifier says whether a completed frame may enter the receive buffer. A guard on master mode rejects an enable that arrives after the transmitter is already on, and records the event in a sticky error flag.

Top module: `serCmdUnit`

## Requirements
- R1: Only a write (busWe=1) to address 0x00C acts. Writes to any other address have no effect, and write-data bits 31:12 are ignored.
- R2: All flags and pulses are 0 after reset. A write with a data bit at 0 leaves the matching state unchanged.
- R3: If the set bit and the clear bit of one pair are both 1 in a single write, the clear bit wins. This applies to every pair.
- R4: Bit 0 sets rxEnabled and bit 1 clears it. Bit 2 sets txEnabled and bit 3 clears it. Each flag changes on the clock edge that accepts the write.
- R5: Bit 6 sets rxBlocked and bit 7 clears it. rxLoad can be 1 only when rxFrameDone=1, rxEnabled=1 and rxBlocked=0.
- R6: A write with bit 1 set, while rxEnabled=1 and rxFrameActive=1, gives rxAbort=1 for exactly the one cycle after the write.
- R7: Bit 8 sets txTristate, which puts the transmitter output in high impedance. Bit 9 clears it.
- R8: Bit 4 sets masterMode only if txEnabled was 0 before the write. This means bit 4 is legal in the same write as bit 2. When bit 4 arrives with txEnabled already 1, masterMode is left unchanged and orderErr becomes 1 and stays 1 until reset.
- R9: Bit 5 clears masterMode, which returns the port to slave mode.
- R10: Bit 10 gives rxFlush=1 and bit 11 gives txFlush=1, each for exactly the one cycle after the write.
- R11: rxLoad is 0 in the cycle a clear-RX write is presented and in the cycle rxFlush is 1, even when a frame completes in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 12 | Register byte address |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| rxFrameActive | input | 1 | Receiver is partway through a frame |
| rxFrameDone | input | 1 | Receiver completed a frame this cycle |
| rxEnabled | output | 1 | Receiver enable flag |
| txEnabled | output | 1 | Transmitter enable flag |
| masterMode | output | 1 | Master mode flag (0 = slave) |
| rxBlocked | output | 1 | Receive blocking flag |
| txTristate | output | 1 | Transmitter output high-impedance |
| orderErr | output | 1 | Sticky flag: master enable arrived while transmitter on |
| rxFlush | output | 1 | One-cycle receive buffer and shift register flush |
| txFlush | output | 1 | One-cycle transmit buffer and shift register flush |
| rxAbort | output | 1 | One-cycle discard of the frame under reception |
| rxLoad | output | 1 | Completed frame may enter the receive buffer |

## Verification
Random writes with dense command bits make set and clear bits meet often in one write. This separates clear-wins from set-wins. Mixing in off-address writes and junk in the reserved bits checks that nothing leaks past the decode. Directed sequences try master enable before, with and after the transmitter enable, which tells the legal orderings apart from the rejected one. Other directed sequences time a clear-RX write and the following flush cycle against a completing frame, and switch off the receiver with and without a frame in flight.

// File: rtl/serCmdPkg.sv
package serCmdPkg;
  localparam int unsigned CMD_BITS = 12;
  localparam int unsigned NPAIR    = 4;   // 0 rx, 1 tx, 2 block, 3 tristate

  typedef struct packed {
    logic             clrTx;
    logic             clrRx;
    logic             mstDis;
    logic             mstEn;
    logic [NPAIR-1:0] pairClr;
    logic [NPAIR-1:0] pairSet;
  } cmdStrb_t;
endpackage

// File: rtl/serCmdDecode.sv
module serCmdDecode
  import serCmdPkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  parameter logic [ADDR_W-1:0] CMD_OFFSET = 12'h00C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output cmdStrb_t          strb
);
  // Bit positions of the command word that the decode relies on
  localparam int unsigned SET_POS [NPAIR] = '{0, 2, 6, 8};
  localparam int unsigned CLR_POS [NPAIR] = '{1, 3, 7, 9};
  localparam int unsigned MST_EN_POS  = 4;
  localparam int unsigned MST_DIS_POS = 5;
  localparam int unsigned CLR_RX_POS  = 10;
  localparam int unsigned CLR_TX_POS  = 11;

  logic                cmdHit;
  logic [CMD_BITS-1:0] cmdWord;

  assign cmdHit  = busWe && (busAddr == CMD_OFFSET);
  assign cmdWord = cmdHit ? busWdata[CMD_BITS-1:0] : '0;   // upper bits reserved

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    assign strb.pairSet[i] = cmdWord[SET_POS[i]];
    assign strb.pairClr[i] = cmdWord[CLR_POS[i]];
  end

  assign strb.mstEn  = cmdWord[MST_EN_POS];
  assign strb.mstDis = cmdWord[MST_DIS_POS];
  assign strb.clrRx  = cmdWord[CLR_RX_POS];
  assign strb.clrTx  = cmdWord[CLR_TX_POS];

  // R1: no strobe leaves the decode without an addressed write
  p_quiet_without_hit_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && busAddr == CMD_OFFSET) |-> (strb == '0));
endmodule

// File: rtl/serCmdState.sv
module serCmdState
  import serCmdPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  cmdStrb_t strb,
  input  logic     rxFrameActive,
  input  logic     rxFrameDone,
  output logic     rxEnabled,
  output logic     txEnabled,
  output logic     masterMode,
  output logic     rxBlocked,
  output logic     txTristate,
  output logic     orderErr,
  output logic     rxFlush,
  output logic     txFlush,
  output logic     rxAbort,
  output logic     rxLoad
);
  localparam int unsigned IDX_RX  = 0;
  localparam int unsigned IDX_TX  = 1;
  localparam int unsigned IDX_BLK = 2;
  localparam int unsigned IDX_TRI = 3;

  logic [NPAIR-1:0] pairQ;

  // Set/clear pairs: clear dominates set
  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                pairQ[i] <= 1'b0;
      else if (strb.pairClr[i]) pairQ[i] <= 1'b0;
      else if (strb.pairSet[i]) pairQ[i] <= 1'b1;
    end
  end

  assign rxEnabled  = pairQ[IDX_RX];
  assign txEnabled  = pairQ[IDX_TX];
  assign rxBlocked  = pairQ[IDX_BLK];
  assign txTristate = pairQ[IDX_TRI];

  logic mstIllegal;
  assign mstIllegal = strb.mstEn && txEnabled;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      masterMode <= 1'b0;
      orderErr   <= 1'b0;
      rxFlush    <= 1'b0;
      txFlush    <= 1'b0;
      rxAbort    <= 1'b0;
    end else begin
      if (strb.mstDis)                   masterMode <= 1'b0;
      else if (strb.mstEn && !txEnabled) masterMode <= 1'b1;
      if (mstIllegal) orderErr <= 1'b1;
      rxFlush <= strb.clrRx;
      txFlush <= strb.clrTx;
      rxAbort <= strb.pairClr[IDX_RX] && rxEnabled && rxFrameActive;
    end
  end

  // Frame gating: flush in either stage beats a completing frame
  assign rxLoad = rxFrameDone && rxEnabled && !rxBlocked && !rxFlush && !strb.clrRx;

  p_clear_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pairSet[IDX_RX] && strb.pairClr[IDX_RX]) |=> !rxEnabled);
  p_no_load_blocked_r5: assert property (@(posedge clk) disable iff (!rstN)
    rxBlocked |-> !rxLoad);
  p_abort_leaves_rx_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxAbort |-> !rxEnabled);
  p_master_order_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(masterMode) |-> !$past(txEnabled));
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    orderErr |=> orderErr);
  p_flush_follows_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrTx |=> txFlush);
  p_flush_beats_load_r11: assert property (@(posedge clk) disable iff (!rstN)
    rxFlush |-> !rxLoad);
endmodule

// File: rtl/serCmdUnit.sv
module serCmdUnit
  import serCmdPkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  parameter logic [ADDR_W-1:0] CMD_OFFSET = 12'h00C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              rxFrameActive,
  input  logic              rxFrameDone,
  output logic              rxEnabled,
  output logic              txEnabled,
  output logic              masterMode,
  output logic              rxBlocked,
  output logic              txTristate,
  output logic              orderErr,
  output logic              rxFlush,
  output logic              txFlush,
  output logic              rxAbort,
  output logic              rxLoad
);
  cmdStrb_t strb;

  serCmdDecode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_OFFSET(CMD_OFFSET)) u_decode (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .strb(strb)
  );

  serCmdState u_state (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rxFrameActive(rxFrameActive), .rxFrameDone(rxFrameDone),
    .rxEnabled(rxEnabled), .txEnabled(txEnabled), .masterMode(masterMode),
    .rxBlocked(rxBlocked), .txTristate(txTristate), .orderErr(orderErr),
    .rxFlush(rxFlush), .txFlush(txFlush), .rxAbort(rxAbort), .rxLoad(rxLoad)
  );
endmodule

// File: tb/serCmdUnit_tb.sv
`timescale 1ns/1ps
module serCmdUnit_tb;
  localparam logic [11:0] CMD = 12'h00C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic        rxFrameActive = 1'b0;
  logic        rxFrameDone = 1'b0;
  logic rxEnabled, txEnabled, masterMode, rxBlocked, txTristate;
  logic orderErr, rxFlush, txFlush, rxAbort, rxLoad;

  always #2.5 clk = ~clk;

  serCmdUnit u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .rxFrameActive(rxFrameActive), .rxFrameDone(rxFrameDone),
    .rxEnabled(rxEnabled), .txEnabled(txEnabled), .masterMode(masterMode),
    .rxBlocked(rxBlocked), .txTristate(txTristate), .orderErr(orderErr),
    .rxFlush(rxFlush), .txFlush(txFlush), .rxAbort(rxAbort), .rxLoad(rxLoad)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string phase = "R2 reset";

  // Reference state
  bit mRx, mTx, mMst, mBlk, mTri, mErr, mRxF, mTxF, mAb;

  task automatic check(string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", phase, name, act, exp);
    end
  endtask

  task automatic checkRegs();
    check("rxEnabled R4", rxEnabled, mRx);
    check("txEnabled R4", txEnabled, mTx);
    check("masterMode R8/R9", masterMode, mMst);
    check("rxBlocked R5", rxBlocked, mBlk);
    check("txTristate R7", txTristate, mTri);
    check("orderErr R8", orderErr, mErr);
    check("rxFlush R10", rxFlush, mRxF);
    check("txFlush R10", txFlush, mTxF);
    check("rxAbort R6", rxAbort, mAb);
  endtask

  function automatic bit setClr(bit q, bit s, bit c);
    return c ? 1'b0 : (s ? 1'b1 : q);
  endfunction

  // One cycle: check registers, drive, check rxLoad, advance model
  task automatic cyc(logic [11:0] a, logic we, logic [31:0] wd, logic act, logic dn);
    bit [11:0] s;
    bit expLoad;
    checkRegs();
    busAddr = a; busWe = we; busWdata = wd; rxFrameActive = act; rxFrameDone = dn;
    #1;
    s = (we && a == CMD) ? wd[11:0] : 12'h0;
    expLoad = dn && mRx && !mBlk && !mRxF && !s[10];
    check("rxLoad R11/R5", rxLoad, expLoad);
    mAb  = s[1] && mRx && act;
    mErr = mErr || (s[4] && mTx);
    mMst = s[5] ? 1'b0 : ((s[4] && !mTx) ? 1'b1 : mMst);
    mRx  = setClr(mRx,  s[0], s[1]);
    mTx  = setClr(mTx,  s[2], s[3]);
    mBlk = setClr(mBlk, s[6], s[7]);
    mTri = setClr(mTri, s[8], s[9]);
    mRxF = s[10];
    mTxF = s[11];
    @(negedge clk);
  endtask

  task automatic wr(logic [31:0] wd);
    cyc(CMD, 1'b1, wd, 1'b0, 1'b0);
  endtask

  task automatic idle();
    cyc(CMD, 1'b0, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    busWe = 1'b0;
    {mRx, mTx, mMst, mBlk, mTri, mErr, mRxF, mTxF, mAb} = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    doReset();
    phase = "R2 reset state";
    idle();

    phase = "R2 zero write no effect";
    wr(32'h0000_0145); wr(32'h0); idle();

    phase = "R1 other address ignored";
    cyc(12'h008, 1'b1, 32'h0000_0FFF, 1'b0, 1'b0);
    cyc(12'h00C, 1'b0, 32'h0000_0FFF, 1'b0, 1'b0);
    idle();
    phase = "R1 reserved bits ignored";
    wr(32'hFFFF_F000); idle();

    phase = "R3 clear wins";
    wr(32'h0000_03FF); idle();
    wr(32'h0000_0155); wr(32'h0000_03FF); idle();

    doReset();
    phase = "R8 master and tx same write legal";
    wr(32'h0000_0014); idle();
    phase = "R9 master disable";
    wr(32'h0000_0020); idle();
    phase = "R8 master after tx rejected";
    wr(32'h0000_0010); idle(); wr(32'h0000_0008); idle(); idle();

    doReset();
    phase = "R5 blocking gates load";
    wr(32'h1); cyc(CMD, 1'b0, 0, 1'b1, 1'b1);
    wr(32'h40); cyc(CMD, 1'b0, 0, 1'b1, 1'b1);
    wr(32'h80); cyc(CMD, 1'b0, 0, 1'b1, 1'b1);
    phase = "R11 flush beats completing frame";
    cyc(CMD, 1'b1, 32'h400, 1'b1, 1'b1);
    cyc(CMD, 1'b0, 0, 1'b1, 1'b1);
    cyc(CMD, 1'b0, 0, 1'b1, 1'b1);
    phase = "R10 tx flush pulse";
    wr(32'h800); idle(); idle();
    phase = "R6 abort mid frame";
    cyc(CMD, 1'b1, 32'h2, 1'b1, 1'b0); idle(); idle();
    phase = "R6 disable with no frame";
    wr(32'h1); cyc(CMD, 1'b1, 32'h2, 1'b0, 1'b0); idle();
    phase = "R7 tristate";
    wr(32'h100); idle(); wr(32'h200); idle();

    phase = "R4 random mix";
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] a;
      logic [31:0] d;
      a = ($urandom % 5 == 0) ? 12'($urandom) : CMD;
      d = ($urandom % 4 == 0) ? $urandom : ($urandom & 32'h0000_0FFF & $urandom);
      if (i % 700 == 699) doReset();
      cyc(a, 1'($urandom % 3 != 0), d, 1'($urandom), 1'($urandom));
    end
    idle();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule